// File: doc/BRIEF.md
# Two-Axis Calibration Sequencer

This block is the supervisory controller of a two-axis light tracker. At rest it sits in a manual jog mode. In this mode four direction buttons move the pan servo and the tilt servo directly. A press of the start button launches a fixed calibration run of four phases:

- a pan sweep,
- a pan return to the brightest point,
- a tilt sweep,
- a tilt return.

After the tilt return the block drops back to manual.

The block counts no time of its own. External counters run the sweeps and the return. Each counter hands back a level that stays high while its phase should keep moving, and the sequencer reads the falling of that level as the phase being finished. The sequencer drives one enable per servo direction. It also enables the pan-sweep counter, the tilt-sweep counter and the return counter (count-down while returning), and it holds the return counter cleared while idle. Buttons are taken as already debounced and synchronous to the clock. All outputs are combinational from the state register and the current inputs.

Top module: `cal_sequencer`

## Requirements
- R1: A low `rst_n` at a rising clock edge puts the block in manual. With no button pressed, the outputs afterwards are then all low except `ret_hold`, which is high.
- R2: In manual with start not pressed, `btn_left`/`btn_right` drive `servo_left`/`servo_right` and `btn_up`/`btn_down` drive `servo_up`/`servo_down`. When both buttons of one axis are pressed, neither servo of that axis is enabled.
- R3: In manual with start not pressed, `pan_cnt_en`, `tilt_cnt_en` and `ret_cnt_en` are low and `ret_hold` is high.
- R4: In manual with `btn_start` high, that cycle shows `pan_cnt_en` high and every other output low, including all servos and `ret_hold`. The pan sweep begins at the next edge.
- R5: In pan sweep with `pan_run` high, `servo_left` and `pan_cnt_en` are high. With `pan_run` low, only `ret_cnt_en` is high and the block moves to pan return at the next edge.
- R6: In pan return, `ret_cnt_en` is high. With `ret_run` high, `servo_right` is also high. With `ret_run` low, `tilt_cnt_en` is high instead, no servo is enabled, and the block moves to tilt sweep at the next edge.
- R7: In tilt sweep with `tilt_run` high, `servo_up` and `tilt_cnt_en` are high. With `tilt_run` low, only `ret_cnt_en` is high and the block moves to tilt return at the next edge.
- R8: In tilt return, `ret_cnt_en` is high. With `ret_run` high, `servo_down` is also high. With `ret_run` low, no servo is enabled and the block returns to manual at the next edge.
- R9: In every calibration phase, the four direction buttons and the start button have no effect on any output or on the phase sequence.
- R10: `ret_hold` is low in every calibration phase.
- R11: `servo_left` and `servo_right` are never high together, nor are `servo_up` and `servo_down`. During calibration at most one servo enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_left | input | 1 | Jog pan towards sweep direction |
| btn_right | input | 1 | Jog pan towards return direction |
| btn_up | input | 1 | Jog tilt towards sweep direction |
| btn_down | input | 1 | Jog tilt towards return direction |
| btn_start | input | 1 | Launch calibration from manual |
| pan_run | input | 1 | Pan sweep counter still running |
| tilt_run | input | 1 | Tilt sweep counter still running |
| ret_run | input | 1 | Return counter requests drive-back |
| servo_left | output | 1 | Pan servo enable, sweep direction |
| servo_right | output | 1 | Pan servo enable, return direction |
| servo_up | output | 1 | Tilt servo enable, sweep direction |
| servo_down | output | 1 | Tilt servo enable, return direction |
| pan_cnt_en | output | 1 | Pan sweep counter enable |
| tilt_cnt_en | output | 1 | Tilt sweep counter enable |
| ret_cnt_en | output | 1 | Return counter enable (count-down) |
| ret_hold | output | 1 | Hold return counter cleared |

## Verification
Two kinds of event can fall in the same cycle. In manual, a jog press can coincide with the start press, and start must win: no servo moves and only the pan counter is enabled. In a return phase, the end of the drive-back request coincides with the hand-off to the next counter. The bench drives random button patterns and random run levels every cycle, so start lands together with jog presses and on top of pressed opposite pairs. Run levels drop in the very cycle a phase is entered. A behavioural model computes the full output vector for each cycle and the next phase, and both are compared on every cycle.

// File: rtl/cal_seq_pkg.sv
// Shared definitions for the two-axis calibration sequencer.
// Assumes axis 0 is pan (left/right) and axis 1 is tilt (up/down).
package cal_seq_pkg;

    localparam int NUM_AXES  = 2;
    localparam int AXIS_PAN  = 0;
    localparam int AXIS_TILT = 1;
    localparam int STATE_W   = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_MANUAL    = 3'd0,
        ST_PAN_SWEEP = 3'd1,
        ST_PAN_BACK  = 3'd2,
        ST_TILT_SWEEP = 3'd3,
        ST_TILT_BACK = 3'd4
    } cal_state_e;

endpackage

// File: rtl/cal_seq_jog.sv
// Manual jog arbiter for one axis.
// Passes a press through to its servo direction; a conflicting pair of
// presses enables neither direction. Assumes synchronous, clean inputs.
module cal_seq_jog (
    input  logic press_fwd,
    input  logic press_rev,
    output logic jog_fwd,
    output logic jog_rev
);

    // Mutually exclusive direction request.
    always_comb begin
        jog_fwd = press_fwd & ~press_rev;
        jog_rev = press_rev & ~press_fwd;
    end

endmodule

// File: rtl/cal_seq_phase.sv
// Phase register and next-phase logic of the calibration sequencer.
// Each phase ends when its external run level is seen low; start only
// matters in manual. Reset is synchronous and active low.
module cal_seq_phase
    import cal_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NUM_AXES-1:0] sweep_run,
    input  logic                back_run,
    output cal_state_e          state
);

    cal_state_e state_nxt;

    // Next phase selection from the current phase and the run levels.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_MANUAL:     if (start)                   state_nxt = ST_PAN_SWEEP;
            ST_PAN_SWEEP:  if (!sweep_run[AXIS_PAN])    state_nxt = ST_PAN_BACK;
            ST_PAN_BACK:   if (!back_run)               state_nxt = ST_TILT_SWEEP;
            ST_TILT_SWEEP: if (!sweep_run[AXIS_TILT])   state_nxt = ST_TILT_BACK;
            ST_TILT_BACK:  if (!back_run)               state_nxt = ST_MANUAL;
            default:                                    state_nxt = ST_MANUAL;
        endcase
    end

    // Phase register with synchronous reset to manual.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_MANUAL;
        else        state <= state_nxt;
    end

endmodule

// File: rtl/cal_seq_drive.sv
// Output decoder of the calibration sequencer.
// Sweeps move an axis in its forward direction; returns move it in reverse.
// All enables default low; the return counter is held cleared only in
// manual while start is not pressed.
module cal_seq_drive
    import cal_seq_pkg::*;
(
    input  cal_state_e          state,
    input  logic                start,
    input  logic [NUM_AXES-1:0] jog_fwd,
    input  logic [NUM_AXES-1:0] jog_rev,
    input  logic [NUM_AXES-1:0] sweep_run,
    input  logic                back_run,
    output logic [NUM_AXES-1:0] servo_fwd,
    output logic [NUM_AXES-1:0] servo_rev,
    output logic [NUM_AXES-1:0] sweep_en,
    output logic                back_en,
    output logic                back_hold
);

    // Per-phase output decode with default-low enables.
    always_comb begin
        servo_fwd = '0;
        servo_rev = '0;
        sweep_en  = '0;
        back_en   = 1'b0;
        back_hold = 1'b0;
        unique case (state)
            ST_MANUAL: begin
                if (start) begin
                    sweep_en[AXIS_PAN] = 1'b1;
                end else begin
                    servo_fwd = jog_fwd;
                    servo_rev = jog_rev;
                    back_hold = 1'b1;
                end
            end
            ST_PAN_SWEEP: begin
                if (sweep_run[AXIS_PAN]) begin
                    servo_fwd[AXIS_PAN] = 1'b1;
                    sweep_en[AXIS_PAN]  = 1'b1;
                end else begin
                    back_en = 1'b1;
                end
            end
            ST_PAN_BACK: begin
                back_en = 1'b1;
                if (back_run) servo_rev[AXIS_PAN] = 1'b1;
                else          sweep_en[AXIS_TILT] = 1'b1;
            end
            ST_TILT_SWEEP: begin
                if (sweep_run[AXIS_TILT]) begin
                    servo_fwd[AXIS_TILT] = 1'b1;
                    sweep_en[AXIS_TILT]  = 1'b1;
                end else begin
                    back_en = 1'b1;
                end
            end
            ST_TILT_BACK: begin
                back_en = 1'b1;
                if (back_run) servo_rev[AXIS_TILT] = 1'b1;
            end
            default: begin
                back_hold = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cal_sequencer.sv
// Top of the two-axis calibration sequencer.
// Combines manual jog (one arbiter per axis) with a four-phase
// sweep/return calibration handed off by external counter run levels.
// Assumes buttons are debounced and synchronous to clk.
module cal_sequencer
    import cal_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic btn_left,
    input  logic btn_right,
    input  logic btn_up,
    input  logic btn_down,
    input  logic btn_start,
    input  logic pan_run,
    input  logic tilt_run,
    input  logic ret_run,
    output logic servo_left,
    output logic servo_right,
    output logic servo_up,
    output logic servo_down,
    output logic pan_cnt_en,
    output logic tilt_cnt_en,
    output logic ret_cnt_en,
    output logic ret_hold
);

    logic [NUM_AXES-1:0] press_fwd, press_rev;
    logic [NUM_AXES-1:0] jog_fwd, jog_rev;
    logic [NUM_AXES-1:0] run_lvl;
    logic [NUM_AXES-1:0] servo_fwd, servo_rev, sweep_en;
    cal_state_e          state;

    // Gather per-axis inputs into vectors.
    always_comb begin
        press_fwd[AXIS_PAN]  = btn_left;
        press_rev[AXIS_PAN]  = btn_right;
        press_fwd[AXIS_TILT] = btn_up;
        press_rev[AXIS_TILT] = btn_down;
        run_lvl[AXIS_PAN]    = pan_run;
        run_lvl[AXIS_TILT]   = tilt_run;
    end

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        cal_seq_jog u_jog (
            .press_fwd (press_fwd[a]),
            .press_rev (press_rev[a]),
            .jog_fwd   (jog_fwd[a]),
            .jog_rev   (jog_rev[a])
        );
    end

    cal_seq_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (btn_start),
        .sweep_run (run_lvl),
        .back_run  (ret_run),
        .state     (state)
    );

    cal_seq_drive u_drive (
        .state     (state),
        .start     (btn_start),
        .jog_fwd   (jog_fwd),
        .jog_rev   (jog_rev),
        .sweep_run (run_lvl),
        .back_run  (ret_run),
        .servo_fwd (servo_fwd),
        .servo_rev (servo_rev),
        .sweep_en  (sweep_en),
        .back_en   (ret_cnt_en),
        .back_hold (ret_hold)
    );

    // Spread per-axis outputs onto the named ports.
    always_comb begin
        servo_left  = servo_fwd[AXIS_PAN];
        servo_right = servo_rev[AXIS_PAN];
        servo_up    = servo_fwd[AXIS_TILT];
        servo_down  = servo_rev[AXIS_TILT];
        pan_cnt_en  = sweep_en[AXIS_PAN];
        tilt_cnt_en = sweep_en[AXIS_TILT];
    end

endmodule

// File: rtl/cal_sequencer_chk.sv
// Property checker for cal_sequencer, attached by bind.
// Observes the phase register and the ports; drives nothing.
module cal_sequencer_chk
    import cal_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input cal_state_e state,
    input logic       btn_start,
    input logic       pan_run,
    input logic       tilt_run,
    input logic       ret_run,
    input logic       servo_left,
    input logic       servo_right,
    input logic       servo_up,
    input logic       servo_down,
    input logic       pan_cnt_en,
    input logic       tilt_cnt_en,
    input logic       ret_cnt_en,
    input logic       ret_hold
);

    p_pan_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(servo_left && servo_right));

    p_tilt_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(servo_up && servo_down));

    p_single_servo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_MANUAL) |->
        ($countones({servo_left, servo_right, servo_up, servo_down}) <= 1));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MANUAL && !btn_start) |->
        (ret_hold && !pan_cnt_en && !tilt_cnt_en && !ret_cnt_en));

    p_start_enters_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MANUAL && btn_start) |=> (state == ST_PAN_SWEEP));

    p_pan_sweep_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAN_SWEEP && !pan_run) |=> (state == ST_PAN_BACK));

    p_pan_back_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAN_BACK) |-> ret_cnt_en);

    p_tilt_sweep_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TILT_SWEEP && !tilt_run) |=> (state == ST_TILT_BACK));

    p_tilt_back_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TILT_BACK && !ret_run) |=> (state == ST_MANUAL));

    p_hold_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_MANUAL) |-> !ret_hold);

endmodule

bind cal_sequencer cal_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .btn_start   (btn_start),
    .pan_run     (pan_run),
    .tilt_run    (tilt_run),
    .ret_run     (ret_run),
    .servo_left  (servo_left),
    .servo_right (servo_right),
    .servo_up    (servo_up),
    .servo_down  (servo_down),
    .pan_cnt_en  (pan_cnt_en),
    .tilt_cnt_en (tilt_cnt_en),
    .ret_cnt_en  (ret_cnt_en),
    .ret_hold    (ret_hold)
);

// File: tb/cal_sequencer_tb.sv
// Self-checking bench: behavioural reference model compared every cycle.
module cal_sequencer_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_l = 0, b_r = 0, b_u = 0, b_d = 0, b_s = 0;
    logic pr = 0, tr = 0, rr = 0;
    logic s_l, s_r, s_u, s_d, pen, ten, ren, hold;

    int checks = 0;
    int errors = 0;
    int mdl = 0;   // 0 manual, 1 pan sweep, 2 pan back, 3 tilt sweep, 4 tilt back

    always #2 clk = ~clk;

    cal_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .btn_left(b_l), .btn_right(b_r), .btn_up(b_u), .btn_down(b_d),
        .btn_start(b_s), .pan_run(pr), .tilt_run(tr), .ret_run(rr),
        .servo_left(s_l), .servo_right(s_r), .servo_up(s_u), .servo_down(s_d),
        .pan_cnt_en(pen), .tilt_cnt_en(ten), .ret_cnt_en(ren), .ret_hold(hold)
    );

    // Expected {left,right,up,down,pan_en,tilt_en,ret_en,hold}.
    function automatic logic [7:0] expect_vec(int st);
        logic [7:0] v = 8'b0;
        case (st)
            0: if (b_s) v = 8'b0000_1000;
               else v = {b_l && !b_r, b_r && !b_l, b_u && !b_d, b_d && !b_u, 4'b0001};
            1: v = pr ? 8'b1000_1000 : 8'b0000_0010;
            2: v = rr ? 8'b0100_0010 : 8'b0000_0110;
            3: v = tr ? 8'b0010_0100 : 8'b0000_0010;
            4: v = rr ? 8'b0001_0010 : 8'b0000_0010;
            default: v = 8'b0;
        endcase
        return v;
    endfunction

    function automatic int next_phase(int st);
        case (st)
            0: return b_s ? 1 : 0;
            1: return pr ? 1 : 2;
            2: return rr ? 2 : 3;
            3: return tr ? 3 : 4;
            4: return rr ? 4 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int st);
        case (st)
            0: return b_s ? "R4" : "R2/R3/R11";
            1: return "R5/R9/R10";
            2: return "R6/R9/R10";
            3: return "R7/R9/R10";
            default: return "R8/R9/R10";
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [7:0] got, exp;
        got = {s_l, s_r, s_u, s_d, pen, ten, ren, hold};
        exp = expect_vec(mdl);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s phase=%0d actual=%b expected=%b", tag, mdl, got, exp);
        end
    endtask

    // Advance one cycle: inputs already applied; check then clock the model.
    task automatic cycle(input string tag);
        int nxt;
        #1;
        compare(tag);
        nxt = rst_n ? next_phase(mdl) : 0;
        @(posedge clk);
        mdl = nxt;
        @(negedge clk);
    endtask

    task automatic set_in(input logic l, r, u, d, s, p, t, q);
        b_l = l; b_r = r; b_u = u; b_d = d; b_s = s; pr = p; tr = t; rr = q;
    endtask

    initial begin
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mdl = 0;
        // R1: idle outputs right after reset.
        cycle("R1");
        // R2: each jog direction, then conflicting pairs.
        set_in(1,0,0,0,0,0,0,0); cycle("R2");
        set_in(0,1,0,1,0,0,0,0); cycle("R2");
        set_in(1,1,1,1,0,0,0,0); cycle("R2/R11");
        set_in(0,0,1,0,0,0,0,0); cycle("R2");
        // R4: start together with jog presses.
        set_in(1,0,1,0,1,1,1,1); cycle("R4");
        // R5, R9: sweep with noisy buttons; pan sweep ends immediately.
        set_in(0,1,0,1,1,0,1,1); cycle("R5/R9");
        // R6: drive-back two cycles, then hand-off.
        set_in(1,1,1,1,0,0,0,1); cycle("R6");
        set_in(0,0,0,0,1,0,0,1); cycle("R6/R9");
        set_in(0,0,0,0,0,0,0,0); cycle("R6");
        // R7, R8: tilt sweep and return.
        set_in(1,0,0,1,0,0,1,0); cycle("R7");
        set_in(0,0,0,0,0,0,0,0); cycle("R7");
        set_in(0,0,0,0,1,0,0,1); cycle("R8/R9");
        set_in(0,0,0,0,0,0,0,0); cycle("R8");
        set_in(0,1,0,0,0,0,0,0); cycle("R2");
        // Random patterns, including occasional mid-run reset.
        for (int i = 0; i < 4000; i++) begin
            set_in($urandom_range(0,1) == 1, $urandom_range(0,1) == 1,
                   $urandom_range(0,1) == 1, $urandom_range(0,1) == 1,
                   $urandom_range(0,7) == 0, $urandom_range(0,3) != 0,
                   $urandom_range(0,3) != 0, $urandom_range(0,2) != 0);
            rst_n = ($urandom_range(0,99) != 0);
            cycle(tag_of(mdl));
        end
        rst_n = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule